// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects five interrupt sources for a small 8-bit CPU core: two external request pins, two timer overflow flags and one serial port event. It qualifies every source with a global enable and a per-source enable. It then picks one winner using a programmable two-level priority. Within a level, a fixed polling order breaks ties. The winner is presented to the core as a request line and a 16-bit vector address.

The external pins are active low and pass through a synchronizer. Each pin can be configured to latch on a falling edge or to follow a low level. The controller owns the two external request flags and clears the edge-latched ones when the core accepts the interrupt. Timer flags belong to the timers, so the controller returns a one-cycle clear strobe for them on acceptance. The serial event flags are left for software to clear.

A two-bit in-service record, one bit per level, provides nesting. A level-1 request may interrupt a level-0 handler. Nothing interrupts a level-1 handler. A request at the level already in service waits for the return-from-interrupt pulse, which retires the highest active level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_req`, `irq_vec`, `ext_flag` and `tmr_clr` are all zero.
- R2: Source index i (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial) is served at vector 0x0003 + 8*i. A pending, enabled and unblocked source raises `irq_req` with its vector on the clock edge after it becomes pending.
- R3: With `glb_en` low, no request is raised whatever the sources and enables are.
- R4: A source whose bit in `src_en` is 0 is never selected, and a lower-order enabled source is served instead.
- R5: Among pending sources of the same level, the lowest index wins.
- R6: A pending source whose `src_lvl` bit is 1 wins over every level-0 source, regardless of index.
- R7: Acceptance (`cpu_ack` while `irq_req` is high) marks the winner's level in service and drops `irq_req`. A level-1 request may then preempt a level-0 service. A request at an in-service level, or any request while level 1 is in service, is held off.
- R8: A `cpu_reti` pulse retires level 1 if it is in service, otherwise level 0. Held-off requests are then served on the following edge.
- R9: With `ext_edge[k]`=1, a high-to-low change of the synchronized pin k sets `ext_flag[k]` three edges after the pin falls. The flag stays set after the pin returns high and is cleared by acceptance of that source.
- R10: With `ext_edge[k]`=0, `ext_flag[k]` follows the inverted pin with a three-edge delay, and acceptance does not clear it.
- R11: Acceptance of timer 0 or timer 1 drives `tmr_clr` bit 0 or bit 1 high for exactly the next cycle. Acceptance of any other source leaves `tmr_clr` at zero.
- R12: The serial source is pending when either `ser_rx_done` or `ser_tx_done` is high.
- R13: `cpu_ack` while `irq_req` is low has no effect: no level enters service and no clear strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enable, bit i for source i |
| src_lvl | input | 5 | Per-source level, 1 = high level |
| ext_pin_n | input | 2 | Active-low external request pins |
| ext_edge | input | 2 | Per-pin sense: 1 = falling edge, 0 = low level |
| tmr_flag | input | 2 | Timer overflow flags (timer 0, timer 1) |
| ser_rx_done | input | 1 | Serial receive-complete flag |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| cpu_ack | input | 1 | Core accepts the presented interrupt |
| cpu_reti | input | 1 | Core returns from an interrupt handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the request, zero when idle |
| ext_flag | output | 2 | External request flags |
| tmr_clr | output | 2 | One-cycle clear strobes to the timers |

## Verification
The embedded properties watch every cycle for these invariants: vectors always lie on the legal grid, a disabled global enable always silences the next request, an active level-1 service always blocks requests, and acceptance always enters a level. They also check that a return from two nested levels leaves only level 0, that clear strobes never fire together, and that the external flag latches or follows the pin as its mode dictates. Only the bench scenarios can show the outcome of arbitration for particular mixes of enables and levels. They also show the exact latency from pin to flag to request, that preemption and deferral happen in the right order across a nested sequence, and that a stray acknowledge leaves no trace.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NUM_SRC    = 5;
    localparam int NUM_EXT    = 2;
    localparam int NUM_TMR    = 2;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_SHIFT  = 3;

    // Source index assignment (fixed polling order, lowest index wins)
    localparam logic [IDX_W-1:0] SRC_EXT0 = IDX_W'(0);
    localparam logic [IDX_W-1:0] SRC_TMR0 = IDX_W'(1);
    localparam logic [IDX_W-1:0] SRC_EXT1 = IDX_W'(2);
    localparam logic [IDX_W-1:0] SRC_TMR1 = IDX_W'(3);
    localparam logic [IDX_W-1:0] SRC_SER  = IDX_W'(4);

    typedef logic [IDX_W-1:0] src_idx_t;

    // State of the service/arbitration front end
    typedef struct packed {
        logic             req;
        src_idx_t         idx;
        logic             lvl;
        logic [1:0]       isr;
        logic [NUM_TMR-1:0] tclr;
    } ctrl_st_t;

    function automatic logic [VEC_W-1:0] vec_of(input src_idx_t idx);
        return VEC_W'(VEC_BASE) + (VEC_W'(idx) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/ext_req_cond.sv
module ext_req_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   flag;
    } cond_st_t;

    cond_st_t st_q, st_d;
    logic     pin_s;
    logic     fall;

    assign pin_s = st_q.sync[SYNC_STAGES-1];
    assign fall  = st_q.prev & ~pin_s;
    assign flag  = st_q.flag;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_n};
        st_d.prev = pin_s;
        if (edge_mode) begin
            if (fall) begin
                st_d.flag = 1'b1;
            end else if (clr) begin
                st_d.flag = 1'b0;
            end
        end else begin
            st_d.flag = ~pin_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sync <= '1;
            st_q.prev <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a detected fall in edge mode is latched on the next edge
    a_r9_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> flag);

    // R10: in level mode the flag mirrors the synchronized pin
    a_r10_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode) |=> (flag == !$past(pin_s)));

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import prio_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     en,
    input  logic [N-1:0]     lvl,
    input  logic             glb,
    input  logic [1:0]       isr,
    output logic             grant,
    output logic [IDX_W-1:0] gidx,
    output logic             glvl
);

    logic [N-1:0]     elig;
    logic [N-1:0]     hi_set;
    logic [N-1:0]     lo_set;
    logic             hi_any;
    logic             lo_any;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;

    always_comb begin
        elig   = pend & en & {N{glb}};
        hi_set = elig & lvl;
        lo_set = elig & ~lvl;
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hi_set[i]) begin
                hi_any = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (lo_set[i]) begin
                lo_any = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
        grant = 1'b0;
        gidx  = '0;
        glvl  = 1'b0;
        if (hi_any && !isr[1]) begin
            grant = 1'b1;
            gidx  = hi_idx;
            glvl  = 1'b1;
        end else if (lo_any && (isr == 2'b00)) begin
            grant = 1'b1;
            gidx  = lo_idx;
            glvl  = 1'b0;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic [NUM_EXT-1:0] ext_edge,
    input  logic [NUM_TMR-1:0] tmr_flag,
    input  logic               ser_rx_done,
    input  logic               ser_tx_done,
    input  logic               cpu_ack,
    input  logic               cpu_reti,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [NUM_EXT-1:0] ext_flag,
    output logic [NUM_TMR-1:0] tmr_clr
);

    localparam src_idx_t EXT_IDX [NUM_EXT] = '{SRC_EXT0, SRC_EXT1};
    localparam src_idx_t TMR_IDX [NUM_TMR] = '{SRC_TMR0, SRC_TMR1};

    ctrl_st_t           st_q, st_d;
    logic               ack_fire;
    logic [NUM_EXT-1:0] ext_clr;
    logic [NUM_SRC-1:0] pend;
    logic               grant;
    src_idx_t           gidx;
    logic               glvl;

    assign ack_fire = cpu_ack & st_q.req;

    // External request conditioning, one per pin
    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        assign ext_clr[k] = ack_fire && (st_q.idx == EXT_IDX[k]);
        ext_req_cond #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[k]),
            .edge_mode (ext_edge[k]),
            .clr       (ext_clr[k]),
            .flag      (ext_flag[k])
        );
    end

    always_comb begin
        pend           = '0;
        pend[SRC_EXT0] = ext_flag[0];
        pend[SRC_TMR0] = tmr_flag[0];
        pend[SRC_EXT1] = ext_flag[1];
        pend[SRC_TMR1] = tmr_flag[1];
        pend[SRC_SER]  = ser_rx_done | ser_tx_done;
    end

    irq_resolver #(
        .N (NUM_SRC)
    ) u_res (
        .pend  (pend),
        .en    (src_en),
        .lvl   (src_lvl),
        .glb   (glb_en),
        .isr   (st_q.isr),
        .grant (grant),
        .gidx  (gidx),
        .glvl  (glvl)
    );

    always_comb begin
        st_d = st_q;
        // return retires the highest active level
        if (cpu_reti) begin
            if (st_q.isr[1]) begin
                st_d.isr[1] = 1'b0;
            end else begin
                st_d.isr[0] = 1'b0;
            end
        end
        if (ack_fire) begin
            st_d.isr[st_q.lvl] = 1'b1;
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            st_d.tclr[t] = ack_fire && (st_q.idx == TMR_IDX[t]);
        end
        st_d.req = grant & ~ack_fire;
        if (grant && !ack_fire) begin
            st_d.idx = gidx;
            st_d.lvl = glvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req = st_q.req;
    assign irq_vec = st_q.req ? vec_of(st_q.idx) : '0;
    assign tmr_clr = st_q.tclr;

    // R2: presented vectors lie on the legal grid
    a_r2_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[VEC_SHIFT-1:0] == VEC_SHIFT'(VEC_BASE)
                     && (irq_vec >> VEC_SHIFT) < VEC_W'(NUM_SRC)));

    // R3: global disable silences the following request
    a_r3_glb_block: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(glb_en) |-> !irq_req);

    // R7: nothing is raised while level 1 was in service
    a_r7_l1_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.isr[1]) |-> !irq_req);

    // R7: acceptance always enters a level
    a_r7_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (st_q.isr != 2'b00));

    // R8: return from nested service leaves level 0 only
    a_r8_reti_nested: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reti && !ack_fire && st_q.isr == 2'b11) |=> (st_q.isr == 2'b01));

    // R11: at most one timer clear strobe at a time
    a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_clr));

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic [4:0]  src_en = '0;
    logic [4:0]  src_lvl = '0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  ext_edge = 2'b00;
    logic [1:0]  tmr_flag = '0;
    logic        ser_rx_done = 1'b0;
    logic        ser_tx_done = 1'b0;
    logic        cpu_ack = 1'b0;
    logic        cpu_reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [1:0]  ext_flag;
    logic [1:0]  tmr_clr;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .glb_en      (glb_en),
        .src_en      (src_en),
        .src_lvl     (src_lvl),
        .ext_pin_n   (ext_pin_n),
        .ext_edge    (ext_edge),
        .tmr_flag    (tmr_flag),
        .ser_rx_done (ser_rx_done),
        .ser_tx_done (ser_tx_done),
        .cpu_ack     (cpu_ack),
        .cpu_reti    (cpu_reti),
        .irq_req     (irq_req),
        .irq_vec     (irq_vec),
        .ext_flag    (ext_flag),
        .tmr_clr     (tmr_clr)
    );

    // Row: {glb, en[4:0], lvl[4:0], tmr[1:0], rx, tx, exp_req, exp_vec[15:0]}
    localparam int ROWS = 11;
    localparam logic [31:0] TABLE [ROWS] = '{
        {1'b1, 5'b11111, 5'b00000, 2'b01, 1'b0, 1'b0, 1'b1, 16'h000B}, // R2 timer 0
        {1'b1, 5'b11111, 5'b00000, 2'b10, 1'b0, 1'b0, 1'b1, 16'h001B}, // R2 timer 1
        {1'b1, 5'b11111, 5'b00000, 2'b11, 1'b0, 1'b0, 1'b1, 16'h000B}, // R5 order
        {1'b1, 5'b11111, 5'b00000, 2'b00, 1'b1, 1'b0, 1'b1, 16'h0023}, // R12 rx
        {1'b1, 5'b11111, 5'b00000, 2'b00, 1'b0, 1'b1, 1'b1, 16'h0023}, // R12 tx
        {1'b0, 5'b11111, 5'b00000, 2'b11, 1'b1, 1'b0, 1'b0, 16'h0000}, // R3
        {1'b1, 5'b11101, 5'b00000, 2'b11, 1'b0, 1'b0, 1'b1, 16'h001B}, // R4
        {1'b1, 5'b11111, 5'b01000, 2'b11, 1'b0, 1'b0, 1'b1, 16'h001B}, // R6
        {1'b1, 5'b11111, 5'b10000, 2'b11, 1'b1, 1'b0, 1'b1, 16'h0023}, // R6 serial
        {1'b1, 5'b00000, 5'b00000, 2'b11, 1'b1, 1'b1, 1'b0, 16'h0000}, // R4 all off
        {1'b1, 5'b11111, 5'b00000, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0000}  // R2 idle
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ack_pulse();
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic reti_pulse();
        cpu_reti = 1'b1;
        @(negedge clk);
        cpu_reti = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 req", 32'(irq_req), 32'd0);
        chk("R1 vec", 32'(irq_vec), 32'd0);
        chk("R1 flags", {28'd0, ext_flag, tmr_clr}, 32'd0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after release", {15'd0, irq_req, irq_vec}, 32'd0);

        // Arbitration table
        for (int r = 0; r < ROWS; r++) begin
            glb_en      = TABLE[r][31];
            src_en      = TABLE[r][30:26];
            src_lvl     = TABLE[r][25:21];
            tmr_flag    = TABLE[r][20:19];
            ser_rx_done = TABLE[r][18];
            ser_tx_done = TABLE[r][17];
            tick(1);
            chk($sformatf("table row %0d", r), {15'd0, irq_req, irq_vec}, {15'd0, TABLE[r][16:0]});
        end
        glb_en = 1'b1; src_en = 5'b11111; src_lvl = '0;
        tmr_flag = '0; ser_rx_done = 1'b0; ser_tx_done = 1'b0;
        tick(2);

        // R11: timer 0 acceptance and clear strobe
        tmr_flag[0] = 1'b1;
        tick(1);
        chk("R2 timer0 vector", 32'(irq_vec), 32'h000B);
        ack_pulse();
        chk("R11 strobe timer0", 32'(tmr_clr), 32'd1);
        chk("R7 req drops on ack", 32'(irq_req), 32'd0);
        tmr_flag[0] = 1'b0;
        tick(1);
        chk("R11 strobe one cycle", 32'(tmr_clr), 32'd0);

        // R7: same level held off
        tmr_flag[1] = 1'b1;
        tick(2);
        chk("R7 same level waits", 32'(irq_req), 32'd0);

        // R7: level-1 preempts level-0
        src_lvl[4] = 1'b1;
        ser_rx_done = 1'b1;
        tick(1);
        chk("R7 preempt vector", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h0023});
        ack_pulse();
        chk("R11 no strobe for serial", 32'(tmr_clr), 32'd0);

        // R7: nothing preempts level 1
        src_lvl[3] = 1'b1;
        tick(2);
        chk("R7 level1 not preempted", 32'(irq_req), 32'd0);

        // R8: reti retires level 1, held level-1 timer 1 then wins over serial
        reti_pulse();
        chk("R8 req in reti cycle", 32'(irq_req), 32'd0);
        tick(1);
        chk("R8 served after reti", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h001B});
        ack_pulse();
        chk("R11 strobe timer1", 32'(tmr_clr), 32'd2);
        tmr_flag[1] = 1'b0;
        ser_rx_done = 1'b0;
        reti_pulse();
        reti_pulse();
        src_lvl = '0;
        tick(2);
        chk("R8 idle after unwinding", 32'(irq_req), 32'd0);

        // R13: stray acknowledge ignored
        ack_pulse();
        chk("R13 no strobe", 32'(tmr_clr), 32'd0);
        tmr_flag[0] = 1'b1;
        tick(1);
        chk("R13 level 0 still free", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h000B});
        ack_pulse();
        tmr_flag[0] = 1'b0;
        reti_pulse();
        tick(2);

        // R9: falling-edge external 0
        ext_edge = 2'b01;
        ext_pin_n[0] = 1'b0;
        tick(2);
        chk("R9 flag not before third edge", 32'(ext_flag), 32'd0);
        tick(1);
        chk("R9 flag set", 32'(ext_flag), 32'd1);
        ext_pin_n[0] = 1'b1;
        tick(1);
        chk("R9 request ext0", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h0003});
        tick(3);
        chk("R9 flag held after pin high", 32'(ext_flag), 32'd1);
        ack_pulse();
        chk("R9 flag cleared by ack", 32'(ext_flag), 32'd0);
        reti_pulse();
        tick(2);
        chk("R9 no re-request", 32'(irq_req), 32'd0);

        // R10: low-level external 1
        ext_pin_n[1] = 1'b0;
        tick(3);
        chk("R10 flag follows pin", 32'(ext_flag), 32'd2);
        tick(1);
        chk("R10 request ext1", {15'd0, irq_req, irq_vec}, {15'd0, 1'b1, 16'h0013});
        ack_pulse();
        chk("R10 ack leaves flag", 32'(ext_flag), 32'd2);
        ext_pin_n[1] = 1'b1;
        tick(3);
        chk("R10 flag drops with pin", 32'(ext_flag), 32'd0);
        reti_pulse();
        tick(2);
        chk("R10 idle", 32'(irq_req), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule